// File: doc/BRIEF.md
# Three-Wire Banked Control Register

This block takes control words from a host over three wires: a strobe, a shift clock and a data line. All three are sampled in the pixel clock domain. A word is 25 bits long. The bit that arrives first, D00, routes the word to one of two banks.

When the strobe rises, the block waits a fixed number of pixel clocks and copies the shift register into a holding register. A little later it moves the held word into the selected bank. Most fields take effect at that second step. The integration-mode bit waits for line 3 of the field. The shutter fields wait for line 11 in monitoring mode, or for line 93 in still mode.

The decoded fields go straight to the sensor-timing logic next to the block. That logic receives the shutter line count, the field count, the mode bits, five phase selects, a blanking phase, a sample polarity and two gating bits. A word that arrives with too few bits is flagged and discarded.

Top module: `scr_top`

## Requirements
- R1: While `rstN` is low, every output is 0, including `shortWord`.
- R2: Each rising edge of `shiftClkIn` shifts in one bit from `dataIn`. The first bit shifted becomes D00. After 25 or more shifts, the last 25 bits form the word D00..D24.
- R3: Suppose `strobeIn` rises just after a clock edge. The new word is then visible on the outputs after the 8th rising clock edge, and not after the 7th.
- R4: D00=0 writes bank A. At the relatch, the following fields update at once: `shutterMode`=D19, `powerSave`=D20 and `readoutHold`=D22. The bank B outputs do not change.
- R5: D00=1 writes bank B, and all of its fields update at the relatch:
  - `phaseSel`=D15..D01 (phase k is D(3k+3)..D(3k+1)),
  - `blankPhase`=D21..D20,
  - `polarityPos`=D22, `blankGate`=D23 and `clampGate`=D24.
  
  The bank A outputs do not change.
- R6: A `fieldStart` pulse sets the line count to 0. Each `lineStart` pulse increments it. A pending D21 from bank A is copied to `stillMode` (0 means monitoring, 1 means still) on the line pulse that makes the count 3, and on no other.
- R7: Pending bank A shutter fields are applied on the line pulse that makes the count 11 (when `stillMode`=0) or 93 (when `stillMode`=1). They are `shutterLines`=D09..D01 and `fieldCount`=D18..D16.
- R8: Bits D10..D15, D23 and D24 of a bank A word have no effect on any output.
- R9: A strobe that arrives after fewer than 25 shifts sets `shortWord` and changes no bank. The next complete word clears `shortWord`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous clear, active low |
| strobeIn | input | 1 | Asynchronous strobe; its rising edge starts the latch sequence |
| shiftClkIn | input | 1 | Asynchronous shift clock |
| dataIn | input | 1 | Asynchronous serial data |
| lineStart | input | 1 | One-cycle pulse at the start of each line |
| fieldStart | input | 1 | One-cycle pulse at the start of each field |
| shutterLines | output | 9 | Shutter length in lines (deferred) |
| fieldCount | output | 3 | Shutter length in fields (deferred) |
| shutterMode | output | 1 | Electronic shutter mode |
| powerSave | output | 1 | Power save request |
| stillMode | output | 1 | Integration mode, 1 = still (deferred to line 3) |
| readoutHold | output | 1 | Hold readout pulses inactive |
| phaseSel | output | 15 | Five 3-bit phase selects |
| blankPhase | output | 2 | Blanking pulse phase |
| polarityPos | output | 1 | Sample pulse polarity, 1 = positive |
| blankGate | output | 1 | Blanking pulse gating enable |
| clampGate | output | 1 | Clamp pulse gating enable |
| shortWord | output | 1 | Last strobe saw fewer than 25 bits |

## Verification
A bit-order or shift fault shows up in the first word written: a phase select or gate bit lands in the wrong place eight clocks after the strobe rises. A fault in the delay counter moves that update off the eighth edge, so it shows at the very first write.

A fault in the line counter or the pending-valid state stays hidden until a line pulse arrives. It then shows as a mode or shutter change on the wrong line, up to 93 lines after the write. For that reason the deferred fields are checked on the line just before and on the line of their target.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int WORD_BITS = 25;

  // control-to-datapath strobes
  typedef struct packed {
    logic shiftEn;
    logic capture;
    logic relatch;
  } scrStrobes_t;

  // bank A (D00 = 0) field positions
  localparam int A_SHUT_LO  = 1;
  localparam int A_SHUT_W   = 9;
  localparam int A_FLD_LO   = 16;
  localparam int A_FLD_W    = 3;
  localparam int A_SMODE    = 19;
  localparam int A_PSAVE    = 20;
  localparam int A_STILL    = 21;
  localparam int A_HOLD     = 22;

  // bank B (D00 = 1) field positions
  localparam int B_PH_LO    = 1;
  localparam int B_PH_N     = 5;
  localparam int B_PH_W     = 3;
  localparam int B_BLKPH_LO = 20;
  localparam int B_BLKPH_W  = 2;
  localparam int B_POL      = 22;
  localparam int B_BLKG     = 23;
  localparam int B_CLPG     = 24;

  typedef struct packed {
    logic [A_SHUT_W-1:0] lines;
    logic [A_FLD_W-1:0]  fields;
  } shutterSet_t;
endpackage

// File: rtl/scr_ctrl.sv
module scr_ctrl
  import scr_pkg::*;
#(
  parameter int CAP_DLY = 3,
  parameter int REL_DLY = 5
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        strobeIn,
  input  logic        shiftClkIn,
  input  logic        dataIn,
  output scrStrobes_t strobes,
  output logic        dataBit,
  output logic        shortWord
);
  localparam int CW = $clog2(REL_DLY + 1);
  localparam int BW = $clog2(WORD_BITS + 1);

  logic [2:0] stbSync;
  logic [2:0] sckSync;
  logic [1:0] datSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stbSync <= '0;
      sckSync <= '0;
      datSync <= '0;
    end else begin
      stbSync <= {stbSync[1:0], strobeIn};
      sckSync <= {sckSync[1:0], shiftClkIn};
      datSync <= {datSync[0], dataIn};
    end
  end

  logic stbRise, sckRise;
  assign stbRise = stbSync[1] & ~stbSync[2];
  assign sckRise = sckSync[1] & ~sckSync[2];
  assign dataBit = datSync[1];

  // delay counter from strobe edge to capture and relatch
  logic          busy;
  logic [CW-1:0] dlyCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      dlyCnt <= '0;
    end else if (stbRise) begin
      busy   <= 1'b1;
      dlyCnt <= CW'(1);
    end else if (busy) begin
      if (dlyCnt == CW'(REL_DLY)) busy <= 1'b0;
      else                        dlyCnt <= dlyCnt + 1'b1;
    end
  end

  logic captureNow;
  assign captureNow = busy && (dlyCnt == CW'(CAP_DLY));

  // bits seen since the last capture, saturating
  logic [BW-1:0] bitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt    <= '0;
      shortWord <= 1'b0;
    end else if (captureNow) begin
      bitCnt    <= '0;
      shortWord <= (bitCnt != BW'(WORD_BITS));
    end else if (sckRise && bitCnt != BW'(WORD_BITS)) begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  assign strobes.shiftEn = sckRise;
  assign strobes.capture = captureNow;
  assign strobes.relatch = busy && (dlyCnt == CW'(REL_DLY)) && !shortWord;
endmodule

// File: rtl/scr_datapath.sv
module scr_datapath
  import scr_pkg::*;
#(
  parameter int LINE_W     = 10,
  parameter int MODE_LINE  = 3,
  parameter int MON_LINE   = 11,
  parameter int STILL_LINE = 93
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  scrStrobes_t              strobes,
  input  logic                     dataBit,
  input  logic                     lineStart,
  input  logic                     fieldStart,
  output logic [A_SHUT_W-1:0]      shutterLines,
  output logic [A_FLD_W-1:0]       fieldCount,
  output logic                     shutterMode,
  output logic                     powerSave,
  output logic                     stillMode,
  output logic                     readoutHold,
  output logic [B_PH_N*B_PH_W-1:0] phaseSel,
  output logic [B_BLKPH_W-1:0]     blankPhase,
  output logic                     polarityPos,
  output logic                     blankGate,
  output logic                     clampGate
);
  logic [WORD_BITS-1:0] shiftReg, holdReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      holdReg  <= '0;
    end else begin
      if (strobes.shiftEn) shiftReg <= {dataBit, shiftReg[WORD_BITS-1:1]};
      if (strobes.capture) holdReg  <= shiftReg;
    end
  end

  logic relA, relB;
  assign relA = strobes.relatch & ~holdReg[0];
  assign relB = strobes.relatch &  holdReg[0];

  // bank B: all fields immediate
  for (genvar g = 0; g < B_PH_N; g++) begin : g_phase
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)     phaseSel[g*B_PH_W +: B_PH_W] <= '0;
      else if (relB) phaseSel[g*B_PH_W +: B_PH_W] <= holdReg[B_PH_LO + g*B_PH_W +: B_PH_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      blankPhase  <= '0;
      polarityPos <= 1'b0;
      blankGate   <= 1'b0;
      clampGate   <= 1'b0;
    end else if (relB) begin
      blankPhase  <= holdReg[B_BLKPH_LO +: B_BLKPH_W];
      polarityPos <= holdReg[B_POL];
      blankGate   <= holdReg[B_BLKG];
      clampGate   <= holdReg[B_CLPG];
    end
  end

  // bank A immediate fields
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shutterMode <= 1'b0;
      powerSave   <= 1'b0;
      readoutHold <= 1'b0;
    end else if (relA) begin
      shutterMode <= holdReg[A_SMODE];
      powerSave   <= holdReg[A_PSAVE];
      readoutHold <= holdReg[A_HOLD];
    end
  end

  // line counter
  logic [LINE_W-1:0] lineCnt, nextLine;
  assign nextLine = (lineCnt == '1) ? lineCnt : lineCnt + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           lineCnt <= '0;
    else if (fieldStart) lineCnt <= '0;
    else if (lineStart)  lineCnt <= nextLine;
  end

  logic lineStep, modeHit, shutHit;
  logic [LINE_W-1:0] shutTarget;
  assign lineStep   = lineStart & ~fieldStart;
  assign shutTarget = stillMode ? LINE_W'(STILL_LINE) : LINE_W'(MON_LINE);
  assign modeHit    = lineStep && (nextLine == LINE_W'(MODE_LINE));
  assign shutHit    = lineStep && (nextLine == shutTarget);

  // deferred bank A fields
  logic        pendStill, pendStillVld;
  shutterSet_t pendShut;
  logic        pendShutVld;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stillMode    <= 1'b0;
      pendStill    <= 1'b0;
      pendStillVld <= 1'b0;
    end else begin
      if (modeHit && pendStillVld) begin
        stillMode    <= pendStill;
        pendStillVld <= 1'b0;
      end
      if (relA) begin
        pendStill    <= holdReg[A_STILL];
        pendStillVld <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shutterLines <= '0;
      fieldCount   <= '0;
      pendShut     <= '0;
      pendShutVld  <= 1'b0;
    end else begin
      if (shutHit && pendShutVld) begin
        shutterLines <= pendShut.lines;
        fieldCount   <= pendShut.fields;
        pendShutVld  <= 1'b0;
      end
      if (relA) begin
        pendShut.lines  <= holdReg[A_SHUT_LO +: A_SHUT_W];
        pendShut.fields <= holdReg[A_FLD_LO +: A_FLD_W];
        pendShutVld     <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/scr_top.sv
module scr_top
  import scr_pkg::*;
#(
  parameter int CAP_DLY    = 3,
  parameter int REL_DLY    = 5,
  parameter int LINE_W     = 10,
  parameter int MODE_LINE  = 3,
  parameter int MON_LINE   = 11,
  parameter int STILL_LINE = 93
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        strobeIn,
  input  logic        shiftClkIn,
  input  logic        dataIn,
  input  logic        lineStart,
  input  logic        fieldStart,
  output logic [8:0]  shutterLines,
  output logic [2:0]  fieldCount,
  output logic        shutterMode,
  output logic        powerSave,
  output logic        stillMode,
  output logic        readoutHold,
  output logic [14:0] phaseSel,
  output logic [1:0]  blankPhase,
  output logic        polarityPos,
  output logic        blankGate,
  output logic        clampGate,
  output logic        shortWord
);
  scrStrobes_t strobes;
  logic        dataBit;
  logic        capturePulse, relatchPulse;

  assign capturePulse = strobes.capture;
  assign relatchPulse = strobes.relatch;

  scr_ctrl #(.CAP_DLY(CAP_DLY), .REL_DLY(REL_DLY)) ctrl_i (
    .clk(clk), .rstN(rstN), .strobeIn(strobeIn), .shiftClkIn(shiftClkIn),
    .dataIn(dataIn), .strobes(strobes), .dataBit(dataBit), .shortWord(shortWord)
  );

  scr_datapath #(
    .LINE_W(LINE_W), .MODE_LINE(MODE_LINE), .MON_LINE(MON_LINE), .STILL_LINE(STILL_LINE)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .dataBit(dataBit),
    .lineStart(lineStart), .fieldStart(fieldStart),
    .shutterLines(shutterLines), .fieldCount(fieldCount), .shutterMode(shutterMode),
    .powerSave(powerSave), .stillMode(stillMode), .readoutHold(readoutHold),
    .phaseSel(phaseSel), .blankPhase(blankPhase), .polarityPos(polarityPos),
    .blankGate(blankGate), .clampGate(clampGate)
  );
endmodule

// File: rtl/scr_checker.sv
module scr_checker (
  input logic        clk,
  input logic        rstN,
  input logic        lineStart,
  input logic        capturePulse,
  input logic        relatchPulse,
  input logic        shortWord,
  input logic [8:0]  shutterLines,
  input logic [2:0]  fieldCount,
  input logic        shutterMode,
  input logic        powerSave,
  input logic        stillMode,
  input logic        readoutHold,
  input logic [14:0] phaseSel,
  input logic [1:0]  blankPhase,
  input logic        polarityPos,
  input logic        blankGate,
  input logic        clampGate
);
  // R1
  a_r1_reset_clear: assert property (@(posedge clk)
    !rstN |-> ({shutterLines, fieldCount, shutterMode, powerSave, stillMode, readoutHold,
                phaseSel, blankPhase, polarityPos, blankGate, clampGate, shortWord} == '0))
    else $error("a_r1_reset_clear");

  // R3
  a_r3_relatch_after_capture: assert property (@(posedge clk) disable iff (!rstN)
    relatchPulse |-> $past(capturePulse, 2))
    else $error("a_r3_relatch_after_capture");

  // R3
  a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({capturePulse, relatchPulse}))
    else $error("a_r3_single_strobe");

  // R4
  a_r4_bank_a_on_relatch: assert property (@(posedge clk) disable iff (!rstN)
    !$stable({shutterMode, powerSave, readoutHold}) |-> $past(relatchPulse))
    else $error("a_r4_bank_a_on_relatch");

  // R5
  a_r5_bank_b_on_relatch: assert property (@(posedge clk) disable iff (!rstN)
    !$stable({phaseSel, blankPhase, polarityPos, blankGate, clampGate}) |-> $past(relatchPulse))
    else $error("a_r5_bank_b_on_relatch");

  // R6
  a_r6_mode_on_line: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(stillMode) |-> $past(lineStart))
    else $error("a_r6_mode_on_line");

  // R7
  a_r7_shutter_on_line: assert property (@(posedge clk) disable iff (!rstN)
    !$stable({shutterLines, fieldCount}) |-> $past(lineStart))
    else $error("a_r7_shutter_on_line");

  // R9
  a_r9_no_relatch_short: assert property (@(posedge clk) disable iff (!rstN)
    relatchPulse |-> !shortWord)
    else $error("a_r9_no_relatch_short");
endmodule

bind scr_top scr_checker chk_i (
  .clk(clk), .rstN(rstN), .lineStart(lineStart),
  .capturePulse(capturePulse), .relatchPulse(relatchPulse), .shortWord(shortWord),
  .shutterLines(shutterLines), .fieldCount(fieldCount), .shutterMode(shutterMode),
  .powerSave(powerSave), .stillMode(stillMode), .readoutHold(readoutHold),
  .phaseSel(phaseSel), .blankPhase(blankPhase), .polarityPos(polarityPos),
  .blankGate(blankGate), .clampGate(clampGate)
);

// File: tb/scr_top_tb.sv
module scr_top_tb_top;
  localparam time HALF = 10ns;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic strobeIn = 1'b0, shiftClkIn = 1'b0, dataIn = 1'b0;
  logic lineStart = 1'b0, fieldStart = 1'b0;
  logic [8:0]  shutterLines;
  logic [2:0]  fieldCount;
  logic        shutterMode, powerSave, stillMode, readoutHold;
  logic [14:0] phaseSel;
  logic [1:0]  blankPhase;
  logic        polarityPos, blankGate, clampGate, shortWord;

  int checks = 0;
  int errors = 0;

  always #HALF clk = ~clk;

  scr_top dut_i (
    .clk(clk), .rstN(rstN), .strobeIn(strobeIn), .shiftClkIn(shiftClkIn), .dataIn(dataIn),
    .lineStart(lineStart), .fieldStart(fieldStart),
    .shutterLines(shutterLines), .fieldCount(fieldCount), .shutterMode(shutterMode),
    .powerSave(powerSave), .stillMode(stillMode), .readoutHold(readoutHold),
    .phaseSel(phaseSel), .blankPhase(blankPhase), .polarityPos(polarityPos),
    .blankGate(blankGate), .clampGate(clampGate), .shortWord(shortWord)
  );

  // bank B stimulus table (D00 = 1)
  localparam logic [24:0] VECS [4] = '{25'h1555555, 25'h0AAAAAB, 25'h1F0E1D3, 25'h0123457};

  function automatic logic [20:0] expB(logic [24:0] w);
    return {w[15:1], w[21:20], w[22], w[23], w[24]};
  endfunction

  function automatic logic [20:0] actB();
    return {phaseSel, blankPhase, polarityPos, blankGate, clampGate};
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic shiftBits(logic [24:0] w, int n);
    for (int i = 0; i < n; i++) begin
      dataIn = w[i];
      shiftClkIn = 1'b0;
      tick(3);
      shiftClkIn = 1'b1;
      tick(3);
    end
    shiftClkIn = 1'b0;
    tick(3);
  endtask

  task automatic strobeWord();
    strobeIn = 1'b1;
    tick(12);
    strobeIn = 1'b0;
    tick(3);
  endtask

  task automatic fieldPulse();
    fieldStart = 1'b1;
    tick(1);
    fieldStart = 1'b0;
    tick(1);
  endtask

  task automatic lines(int n);
    for (int i = 0; i < n; i++) begin
      lineStart = 1'b1;
      tick(1);
      lineStart = 1'b0;
      tick(1);
    end
  endtask

  initial begin
    #(HALF * 2 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [20:0] prevB;
    logic [24:0] w;

    tick(3);
    // R1: reset state
    check("R1 reset outputs", {shutterLines, fieldCount, shutterMode, powerSave, stillMode,
          readoutHold, actB(), shortWord}, '0);
    rstN = 1'b1;
    tick(2);

    // R2 R3 R5: table of bank B words with latency check
    prevB = '0;
    for (int v = 0; v < 4; v++) begin
      shiftBits(VECS[v], 25);
      strobeIn = 1'b1;
      tick(7);
      check("R3 no update after 7 edges", 32'(actB()), 32'(prevB));
      tick(1);
      check("R3 R5 R2 bank B after 8 edges", 32'(actB()), 32'(expB(VECS[v])));
      check("R5 bank A untouched", {shutterMode, powerSave, readoutHold, shutterLines}, '0);
      tick(4);
      strobeIn = 1'b0;
      tick(3);
      prevB = expB(VECS[v]);
    end

    // R4 R8: bank A, monitoring, dummy bits set
    w = '0;
    w[9:1] = 9'h0A5; w[18:16] = 3'd5; w[19] = 1'b1; w[20] = 1'b1; w[22] = 1'b1;
    w[15:10] = 6'h3F; w[24:23] = 2'b11;
    shiftBits(w, 25);
    strobeWord();
    check("R4 immediate fields", {shutterMode, powerSave, readoutHold}, 3'b111);
    check("R4 bank B unchanged", 32'(actB()), 32'(prevB));
    check("R7 shutter not before line", {shutterLines, fieldCount}, '0);

    // R7: monitoring shutter at line 11
    fieldPulse();
    lines(10);
    check("R7 shutter held at line 10", {shutterLines, fieldCount}, '0);
    lines(1);
    check("R7 shutter at line 11", {shutterLines, fieldCount}, {9'h0A5, 3'd5});
    check("R6 still remains monitoring", stillMode, 1'b0);

    // R6 R7: still mode, shutter at line 93
    w = '0;
    w[9:1] = 9'h13C; w[18:16] = 3'd2; w[21] = 1'b1;
    shiftBits(w, 25);
    strobeWord();
    check("R4 immediate fields cleared", {shutterMode, powerSave, readoutHold}, 3'b000);
    fieldPulse();
    lines(2);
    check("R6 mode held at line 2", stillMode, 1'b0);
    lines(1);
    check("R6 mode at line 3", stillMode, 1'b1);
    lines(8);
    check("R7 still shutter held at line 11", {shutterLines, fieldCount}, {9'h0A5, 3'd5});
    lines(81);
    check("R7 still shutter held at line 92", {shutterLines, fieldCount}, {9'h0A5, 3'd5});
    lines(1);
    check("R7 still shutter at line 93", {shutterLines, fieldCount}, {9'h13C, 3'd2});

    // R9: short word discarded
    shiftBits(25'h1FFFFFF, 10);
    strobeWord();
    check("R9 short flag set", shortWord, 1'b1);
    check("R9 bank B unchanged", 32'(actB()), 32'(prevB));
    shiftBits(25'h1FFFFFF, 25);
    strobeWord();
    check("R9 short flag cleared", shortWord, 1'b0);
    check("R9 full word applied", 32'(actB()), 32'(expB(25'h1FFFFFF)));
    prevB = expB(25'h1FFFFFF);

    // R8: bank A word with only dummy bits
    w = '0;
    w[15:10] = 6'h3F; w[24:23] = 2'b11;
    shiftBits(w, 25);
    strobeWord();
    check("R8 immediate fields zero", {shutterMode, powerSave, readoutHold}, 3'b000);
    check("R8 bank B unchanged", 32'(actB()), 32'(prevB));
    fieldPulse();
    lines(3);
    check("R8 R6 mode back to monitoring", stillMode, 1'b0);
    lines(8);
    check("R8 shutter fields zero", {shutterLines, fieldCount}, '0);

    // R1: reset mid-run
    rstN = 1'b0;
    tick(2);
    check("R1 reset mid-run", {shutterLines, fieldCount, shutterMode, powerSave, stillMode,
          readoutHold, actB(), shortWord}, '0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule